// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block holds the digital side of an integrating analog-to-digital converter. It drives one enable for each phase of the conversion: auto-zero, signal integrate, reference de-integrate and zero-integrator. Exactly one enable is high at any time, and each enable closes its own set of analog switches. The block reads a single comparator bit that reports which side of zero the integrator output is on. From that bit it records the input polarity and selects the reference polarity that brings the integrator back toward zero. It then counts the clock periods the return takes.

When the run input is high, every conversion takes the same fixed number of clocks. The signal integrate window has a fixed length. De-integrate ends on the comparator crossing or at a full-scale cap. A zero-integrator phase runs only after an over-range reading, and it ends early when the comparator crosses. Auto-zero takes up whatever clocks remain. When run goes low, the cycle in progress finishes and the converter then waits in auto-zero. The parameters must satisfy CYCLE_LEN > INT_LEN + DEINT_MAX + ZI_MAX.

Top module: `dual_slope_seq`

## Requirements
- R1: Exactly one of az_en, int_en, deint_en, zi_en is high in every clock. During and right after reset, az_en is high, conv_valid is low and conv_count is zero.
- R2: Phases follow the order auto-zero, integrate, de-integrate, optional zero-integrator, then auto-zero again. int_en stays high for exactly INT_LEN clocks.
- R3: While run_hold stays high, the time from the first clock of int_en to the first clock of the next int_en is exactly CYCLE_LEN clocks. Auto-zero takes the remainder.
- R4: The value of comp_in in the last integrate clock is latched as the sign (1 = comparator high = positive input). ref_neg equals that sign throughout de-integrate.
- R5: De-integrate ends in the first clock where comp_in differs from the latched sign. If that is the de-integrate clock with index m (counting from 0), then de-integrate lasted m+1 clocks, conv_count = m and conv_ovr = 0.
- R6: If comp_in does not cross within DEINT_MAX de-integrate clocks, de-integrate lasts DEINT_MAX clocks, conv_count = DEINT_MAX and conv_ovr = 1.
- R7: zi_en is raised only right after an over-range de-integrate. It ends in the first clock where comp_in differs from the sign, or after ZI_MAX clocks, whichever comes first. A crossing at ZI clock index z therefore gives a length of min(z+1, ZI_MAX).
- R8: conv_count, conv_sign and conv_ovr load together in the clock that follows the last de-integrate clock. In that same clock conv_valid is high, for one clock only, and it stays low at every other time.
- R9: With run_hold low, the current cycle still completes. az_en then stays high for as long as run_hold stays low, and no conversion starts. int_en rises one clock after run_hold returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_hold | input | 1 | High: convert continuously. Low: hold in auto-zero after the current cycle |
| comp_in | input | 1 | Comparator bit, high when the integrator output is positive |
| az_en | output | 1 | Auto-zero phase enable |
| int_en | output | 1 | Signal integrate phase enable |
| deint_en | output | 1 | Reference de-integrate phase enable |
| zi_en | output | 1 | Zero-integrator phase enable |
| ref_neg | output | 1 | Reference polarity select used during de-integrate |
| conv_count | output | $clog2(DEINT_MAX+1) | De-integrate count of the last conversion |
| conv_sign | output | 1 | Input polarity of the last conversion |
| conv_ovr | output | 1 | Over-range flag of the last conversion |
| conv_valid | output | 1 | One-clock strobe marking a new result |

## Verification
A wrong phase or counter state shows up at the ports right away. It appears as a phase enable whose length is wrong, and within one conversion it also shows as a cycle whose total differs from CYCLE_LEN. A sign latched from the wrong clock shows on ref_neg in the first de-integrate clock. An off-by-one in the de-integrate count appears in conv_count on the conv_valid strobe that ends the same cycle. A fault in the over-range path surfaces one clock later, as a zero-integrator phase that is missing, misplaced or of the wrong length.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {PH_AZ, PH_INT, PH_DE, PH_ZI} phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // The integrator has crossed zero once the comparator disagrees with the latched sign.
  function automatic logic crossed(input logic comp, input logic sign);
    return comp != sign;
  endfunction
endpackage

// File: rtl/dsc_counter.sv
module dsc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= q + 1'b1;
  end
endmodule

// File: rtl/dsc_phase_ctrl.sv
module dsc_phase_ctrl
  import dsc_pkg::*;
#(
  parameter int CYCLE_LEN = 8192,
  parameter int INT_LEN   = 2048,
  parameter int DEINT_MAX = 4096,
  parameter int ZI_MAX    = 1024,
  parameter int CW        = $clog2(CYCLE_LEN),
  parameter int PW        = $clog2(max3(INT_LEN, DEINT_MAX, ZI_MAX))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          comp,
  input  logic [CW-1:0] cyc_q,
  input  logic [PW-1:0] pc_q,
  output phase_e        ph,
  output logic          sign_q,
  output logic          cyc_end,
  output logic          int_done,
  output logic          de_cross,
  output logic          de_full,
  output logic          zi_end,
  output logic          ph_change
);
  phase_e nxt;

  assign cyc_end  = cyc_q == CW'(CYCLE_LEN - 1);
  assign int_done = (ph == PH_INT) && (pc_q == PW'(INT_LEN - 1));
  assign de_cross = (ph == PH_DE) && crossed(comp, sign_q);
  assign de_full  = (ph == PH_DE) && !de_cross && (pc_q == PW'(DEINT_MAX - 1));
  assign zi_end   = (ph == PH_ZI) && (crossed(comp, sign_q) || pc_q == PW'(ZI_MAX - 1));

  always_comb begin
    nxt = ph;
    unique case (ph)
      PH_AZ:  if (cyc_end && run) nxt = PH_INT;
      PH_INT: if (int_done) nxt = PH_DE;
      PH_DE:  if (de_cross) nxt = PH_AZ;
              else if (de_full) nxt = PH_ZI;
      PH_ZI:  if (zi_end) nxt = PH_AZ;
      default: nxt = PH_AZ;
    endcase
  end

  assign ph_change = nxt != ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_AZ;
      sign_q <= 1'b0;
    end else begin
      ph <= nxt;
      if (int_done) sign_q <= comp;
    end
  end
endmodule

// File: rtl/dsc_result_reg.sv
module dsc_result_reg #(
  parameter int DEINT_MAX = 4096,
  parameter int PW        = 12,
  parameter int RW        = $clog2(DEINT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de_cross,
  input  logic          de_full,
  input  logic          sign_in,
  input  logic [PW-1:0] pc_q,
  output logic [RW-1:0] count,
  output logic          sign,
  output logic          ovr,
  output logic          valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      sign  <= 1'b0;
      ovr   <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= de_cross || de_full;
      if (de_cross || de_full) begin
        count <= de_full ? RW'(DEINT_MAX) : RW'(pc_q);
        sign  <= sign_in;
        ovr   <= de_full;
      end
    end
  end
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int CYCLE_LEN = 8192,
  parameter int INT_LEN   = 2048,
  parameter int DEINT_MAX = 4096,
  parameter int ZI_MAX    = 1024,
  localparam int CW       = $clog2(CYCLE_LEN),
  localparam int PW       = $clog2(max3(INT_LEN, DEINT_MAX, ZI_MAX)),
  localparam int RW       = $clog2(DEINT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_hold,
  input  logic          comp_in,
  output logic          az_en,
  output logic          int_en,
  output logic          deint_en,
  output logic          zi_en,
  output logic          ref_neg,
  output logic [RW-1:0] conv_count,
  output logic          conv_sign,
  output logic          conv_ovr,
  output logic          conv_valid
);
  phase_e        ph;
  logic [CW-1:0] cyc_q;
  logic [PW-1:0] pc_q;
  logic          sign_q, cyc_end, int_done, de_cross, de_full, zi_end, ph_change;
  logic          cyc_clr, cyc_en;

  // The cycle counter freezes on its last value while auto-zero is held.
  assign cyc_clr = (ph == PH_AZ) && cyc_end && run_hold;
  assign cyc_en  = !((ph == PH_AZ) && cyc_end);

  dsc_counter #(.W(CW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(cyc_clr), .en(cyc_en), .q(cyc_q));

  dsc_counter #(.W(PW)) u_pcnt (
    .clk(clk), .rst_n(rst_n), .clr(ph_change), .en(1'b1), .q(pc_q));

  dsc_phase_ctrl #(
    .CYCLE_LEN(CYCLE_LEN), .INT_LEN(INT_LEN), .DEINT_MAX(DEINT_MAX),
    .ZI_MAX(ZI_MAX), .CW(CW), .PW(PW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run_hold), .comp(comp_in),
    .cyc_q(cyc_q), .pc_q(pc_q), .ph(ph), .sign_q(sign_q),
    .cyc_end(cyc_end), .int_done(int_done), .de_cross(de_cross),
    .de_full(de_full), .zi_end(zi_end), .ph_change(ph_change));

  dsc_result_reg #(.DEINT_MAX(DEINT_MAX), .PW(PW), .RW(RW)) u_res (
    .clk(clk), .rst_n(rst_n), .de_cross(de_cross), .de_full(de_full),
    .sign_in(sign_q), .pc_q(pc_q), .count(conv_count), .sign(conv_sign),
    .ovr(conv_ovr), .valid(conv_valid));

  assign az_en    = ph == PH_AZ;
  assign int_en   = ph == PH_INT;
  assign deint_en = ph == PH_DE;
  assign zi_en    = ph == PH_ZI;
  assign ref_neg  = sign_q;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int INT_LEN   = 2048,
  parameter int DEINT_MAX = 4096,
  parameter int ZI_MAX    = 1024,
  parameter int RW        = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_hold,
  input logic          comp_in,
  input logic          az_en,
  input logic          int_en,
  input logic          deint_en,
  input logic          zi_en,
  input logic          ref_neg,
  input logic [RW-1:0] conv_count,
  input logic          conv_ovr,
  input logic          conv_valid,
  input logic          de_cross,
  input logic          de_full
);
  int int_run, zi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_run <= 0;
      zi_run  <= 0;
    end else begin
      int_run <= int_en ? int_run + 1 : 0;
      zi_run  <= zi_en ? zi_run + 1 : 0;
    end
  end

  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({az_en, int_en, deint_en, zi_en}) == 1);
  assert_int_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_en) |-> int_run == INT_LEN);
  assert_int_then_de_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_en) |-> deint_en);
  assert_ref_from_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deint_en) |-> ref_neg == $past(comp_in));
  assert_ref_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (deint_en && $past(deint_en)) |-> $stable(ref_neg));
  assert_cross_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    de_cross |=> (conv_valid && !conv_ovr && az_en));
  assert_full_scale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    de_full |=> (conv_valid && conv_ovr && conv_count == RW'(DEINT_MAX) && zi_en));
  assert_zi_after_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zi_en) |-> (conv_valid && conv_ovr));
  assert_zi_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zi_en |-> zi_run < ZI_MAX);
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> !conv_valid);
  assert_valid_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> ($past(deint_en) && !deint_en));
  assert_hold_az_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (az_en && !run_hold) |=> !int_en);
endmodule

bind dual_slope_seq dsc_checker #(
  .INT_LEN(INT_LEN), .DEINT_MAX(DEINT_MAX), .ZI_MAX(ZI_MAX), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_hold(run_hold), .comp_in(comp_in),
  .az_en(az_en), .int_en(int_en), .deint_en(deint_en), .zi_en(zi_en),
  .ref_neg(ref_neg), .conv_count(conv_count), .conv_ovr(conv_ovr),
  .conv_valid(conv_valid), .de_cross(de_cross), .de_full(de_full));

// File: tb/tb_dual_slope_seq.sv
module tb_dual_slope_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CYC  = 64;
  localparam int INTL = 16;
  localparam int DEM  = 32;
  localparam int ZIM  = 8;
  localparam int RW   = $clog2(DEM + 1);
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_hold = 1'b1;
  logic comp_in = 1'b0;
  logic az_en, int_en, deint_en, zi_en, ref_neg, conv_sign, conv_ovr, conv_valid;
  logic [RW-1:0] conv_count;

  int n_checks = 0;
  int n_fail = 0;
  int ticks = 0;

  dual_slope_seq #(.CYCLE_LEN(CYC), .INT_LEN(INTL), .DEINT_MAX(DEM), .ZI_MAX(ZIM)) dut (
    .clk(clk), .rst_n(rst_n), .run_hold(run_hold), .comp_in(comp_in),
    .az_en(az_en), .int_en(int_en), .deint_en(deint_en), .zi_en(zi_en),
    .ref_neg(ref_neg), .conv_count(conv_count), .conv_sign(conv_sign),
    .conv_ovr(conv_ovr), .conv_valid(conv_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", ticks, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // One conversion: input sign s, crossing after m de-integrate clocks, ZI crossing after z clocks.
  task automatic run_cycle(input int m, input bit s, input int z, input bit hold);
    int ni, nd, nz, na, nv, exp_cnt, exp_nd, exp_nz;
    bit exp_ovr, ref_ok;
    ni = 0; nd = 0; nz = 0; na = 0; nv = 0; ref_ok = 1'b1;
    while (!int_en) begin comp_in = s; @(negedge clk); end
    if (hold) run_hold = 1'b0;
    while (int_en) begin comp_in = s; ni++; @(negedge clk); end
    check(ni == INTL, "R2 integrate length", ni, INTL);
    check(deint_en == 1'b1, "R2 de-integrate follows integrate", deint_en, 1);
    while (deint_en) begin
      nd++;
      if (ref_neg != s) ref_ok = 1'b0;
      comp_in = (nd > m) ? ~s : s;
      @(negedge clk);
    end
    check(ref_ok, "R4 reference polarity", ref_neg, s);
    exp_ovr = m >= DEM;
    exp_cnt = exp_ovr ? DEM : m;
    exp_nd  = exp_ovr ? DEM : m + 1;
    exp_nz  = exp_ovr ? ((z + 1 < ZIM) ? z + 1 : ZIM) : 0;
    check(conv_valid == 1'b1, "R8 strobe after de-integrate", conv_valid, 1);
    check(conv_sign == s, "R4 latched sign", conv_sign, s);
    if (exp_ovr) begin
      check(conv_count == RW'(exp_cnt), "R6 full-scale count", conv_count, exp_cnt);
      check(conv_ovr == 1'b1, "R6 over-range flag", conv_ovr, 1);
      check(nd == exp_nd, "R6 de-integrate length", nd, exp_nd);
    end else begin
      check(conv_count == RW'(exp_cnt), "R5 count", conv_count, exp_cnt);
      check(conv_ovr == 1'b0, "R5 no over-range", conv_ovr, 0);
      check(nd == exp_nd, "R5 de-integrate length", nd, exp_nd);
    end
    while (zi_en) begin
      nz++;
      if (conv_valid) nv++;
      comp_in = (nz > z) ? ~s : s;
      @(negedge clk);
    end
    check(nz == exp_nz, "R7 zero-integrator length", nz, exp_nz);
    while (!int_en && !(hold && na >= 3 * CYC)) begin
      if (conv_valid) nv++;
      comp_in = s;
      na++;
      @(negedge clk);
    end
    check(nv == 1, "R8 single strobe", nv, 1);
    if (hold) begin
      check(az_en && !int_en, "R9 held in auto-zero", az_en, 1);
      run_hold = 1'b1;
      @(negedge clk);
      check(int_en == 1'b1, "R9 restart after release", int_en, 1);
    end else begin
      check(ni + nd + nz + na == CYC, "R3 cycle length", ni + nd + nz + na, CYC);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(az_en && !int_en && !deint_en && !zi_en, "R1 reset phase", az_en, 1);
    check(conv_valid == 1'b0 && conv_count == '0, "R1 reset result", conv_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(az_en == 1'b1, "R1 auto-zero after reset", az_en, 1);
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m <= DEM + 1; m++) begin
        run_cycle(m, s[0], (m * 3) % (ZIM + 2), 1'b0);
      end
    end
    run_cycle(5, 1'b1, 0, 1'b1);
    run_cycle(DEM + 4, 1'b0, ZIM + 3, 1'b1);
    run_cycle(0, 1'b0, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule